// File: doc/BRIEF.md
# Compare Unit with Condition Register

This block compares two 32-bit operands and records the outcome as a 4-bit result in one of eight fields of a 32-bit condition register. The operands can be compared as two's complement integers, as unsigned integers, or as IEEE-754 single-precision values. For integer compares, the fourth result bit copies a sticky summary-overflow flag. That flag lives in a small 32-bit integer exception register, which the block also holds. For float compares, the fourth bit marks an unordered result, meaning that at least one operand is a NaN.

A second update path loads one fixed field from four floating-point status flags. The surrounding pipeline produces those flags. A full-register write port replaces all eight fields at once. A read port exposes the whole register. The exception register has its own write and read ports. Only its summary-overflow, overflow, carry and 7-bit count bits can be written.

All state is registered. A write of any kind becomes visible on the read ports after the next rising clock edge.

Top module: `cmp_cr_unit`

## Requirements
- R1: After an asynchronous active-low reset, `cr_rdata` and `xer_rdata` both read 0.
- R2: Field n occupies `cr_rdata[31-4n:28-4n]`, so field 0 is the top nibble. Within a field, nibble bit 3 is less-than, bit 2 is greater-than, bit 1 is equal, and bit 0 is summary-overflow or unordered. A compare write changes only the field selected by `cmp_field`, and the new value is visible after the next rising edge.
- R3: With `cmp_mode` = 2'b00, the compare treats `op_a` and `op_b` as two's complement signed values.
- R4: With `cmp_mode` = 2'b01, the compare treats `op_a` and `op_b` as unsigned values.
- R5: For integer compares, field bit 0 takes the summary-overflow bit (`xer_rdata[31]`) as it stood before the edge that stores the result. This holds even when an exception-register write happens in the same cycle.
- R6: With `cmp_mode[1]` = 1, the operands are single-precision floats. Infinities order correctly, and +0 and -0 compare equal.
- R7: In a float compare where either operand is a NaN (exponent all ones, fraction nonzero), the field is written as 4'b0001.
- R8: Exactly one of less-than, greater-than and equal is set after every integer compare and after every ordered float compare.
- R9: `cr_we` replaces all eight fields with `cr_wdata` in one cycle. If `cmp_we` is asserted in the same cycle, the compare result wins on its own field.
- R10: `fp_we` loads field 1 with `fp_flags`, ordered {FX, FEX, VX, OX} from bit 3 down to bit 0. This load wins over `cr_we` on field 1, and a compare write to field 1 wins over it.
- R11: `xer_we` stores `xer_wdata` masked to the writable bits: 31 (summary overflow), 30 (overflow), 29 (carry) and 6:0 (count). Bits 28:7 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First compare operand |
| op_b | input | 32 | Second compare operand (register value or immediate) |
| cmp_mode | input | 2 | 00 signed, 01 unsigned, 1x float |
| cmp_field | input | 3 | Destination field index of the compare |
| cmp_we | input | 1 | Compare write strobe |
| cr_wdata | input | 32 | Full condition register write data |
| cr_we | input | 1 | Full condition register write strobe |
| cr_rdata | output | 32 | Condition register contents |
| fp_flags | input | 4 | Float status flags {FX, FEX, VX, OX} |
| fp_we | input | 1 | Float status update strobe for field 1 |
| xer_wdata | input | 32 | Exception register write data |
| xer_we | input | 1 | Exception register write strobe |
| xer_rdata | output | 32 | Exception register contents |

## Verification
Every result in this block is due exactly one rising edge after its strobe: compare results, full writes, status loads and exception-register writes. The bench drives inputs just after a falling edge and drops all strobes at the following falling edge, then checks the read ports there, half a cycle after the single edge that stored the result. For the R5 same-cycle case, the bench writes the exception register and requests a compare in the same cycle. It then expects the compare field to show the old summary-overflow bit and the exception register to show the new one. Both are read at the same sample point.

// File: rtl/cmp_cr_unit.sv
module cmp_cr_unit #(
  parameter int NFIELD   = 8,
  parameter int FP_FIELD = 1,
  parameter logic [31:0] XER_MASK = 32'hE000_007F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [31:0]                op_a,
  input  logic [31:0]                op_b,
  input  logic [1:0]                 cmp_mode,
  input  logic [$clog2(NFIELD)-1:0]  cmp_field,
  input  logic                       cmp_we,
  input  logic [4*NFIELD-1:0]        cr_wdata,
  input  logic                       cr_we,
  output logic [4*NFIELD-1:0]        cr_rdata,
  input  logic [3:0]                 fp_flags,
  input  logic                       fp_we,
  input  logic [31:0]                xer_wdata,
  input  logic                       xer_we,
  output logic [31:0]                xer_rdata
);
  localparam int CRW = 4 * NFIELD;
  localparam int IW  = $clog2(NFIELD);

  logic [CRW-1:0] cr_q, cr_d;
  logic [31:0]    xer_q;
  logic           so_q;

  assign so_q = xer_q[31];

  // integer compare
  logic int_eq, int_lt, int_gt;
  assign int_eq = (op_a == op_b);
  assign int_lt = cmp_mode[0] ? (op_a < op_b) : ($signed(op_a) < $signed(op_b));
  assign int_gt = !int_eq && !int_lt;

  // single-precision compare
  logic a_nan, b_nan, unord, both_zero, mag_lt, mag_gt, f_eq, f_lt, f_gt;
  assign a_nan     = (&op_a[30:23]) && (|op_a[22:0]);
  assign b_nan     = (&op_b[30:23]) && (|op_b[22:0]);
  assign unord     = a_nan || b_nan;
  assign both_zero = ~|op_a[30:0] && ~|op_b[30:0];
  assign mag_lt    = op_a[30:0] < op_b[30:0];
  assign mag_gt    = op_a[30:0] > op_b[30:0];
  assign f_eq      = both_zero || (op_a == op_b);
  assign f_lt      = !f_eq && ((op_a[31] != op_b[31]) ? op_a[31]
                                                      : (op_a[31] ? mag_gt : mag_lt));
  assign f_gt      = !f_eq && !f_lt;

  logic [3:0] res_nib;
  always_comb begin
    if (!cmp_mode[1])  res_nib = {int_lt, int_gt, int_eq, so_q};
    else if (unord)    res_nib = 4'b0001;
    else               res_nib = {f_lt, f_gt, f_eq, 1'b0};
  end

  // priority: compare > float status > full write
  always_comb begin
    cr_d = cr_q;
    if (cr_we) cr_d = cr_wdata;
    if (fp_we) cr_d[CRW-1-4*FP_FIELD -: 4] = fp_flags;
    if (cmp_we) cr_d[CRW-1-4*int'(cmp_field) -: 4] = res_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q  <= '0;
      xer_q <= '0;
    end else begin
      cr_q <= cr_d;
      if (xer_we) xer_q <= xer_wdata & XER_MASK;
    end
  end

  assign cr_rdata  = cr_q;
  assign xer_rdata = xer_q;

  function automatic logic [3:0] nib_at(input logic [CRW-1:0] r, input logic [IW-1:0] i);
    return 4'(r >> (CRW - 4 - 4*int'(i)));
  endfunction

  function automatic logic [CRW-1:0] field_mask(input logic [IW-1:0] i);
    return {4'hF, {(CRW-4){1'b0}}} >> (4*int'(i));
  endfunction

  assert_other_fields_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !cr_we && !fp_we) |=>
      ((cr_rdata & ~field_mask($past(cmp_field))) == ($past(cr_rdata) & ~field_mask($past(cmp_field)))));

  assert_int_so_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !cmp_mode[1]) |=> (nib_at(cr_rdata, $past(cmp_field)) & 4'b0001) == {3'b000, $past(xer_rdata[31])});

  assert_nan_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && cmp_mode[1] && unord) |=> nib_at(cr_rdata, $past(cmp_field)) == 4'b0001);

  assert_one_relation_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !(cmp_mode[1] && unord)) |=> $countones(nib_at(cr_rdata, $past(cmp_field)) & 4'b1110) == 1);

  assert_full_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && !cmp_we && !fp_we) |=> cr_rdata == $past(cr_wdata));

  assert_fp_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_we && !(cmp_we && int'(cmp_field) == FP_FIELD)) |=> nib_at(cr_rdata, IW'(FP_FIELD)) == $past(fp_flags));

  assert_xer_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xer_we |=> xer_rdata == ($past(xer_wdata) & XER_MASK));

  assert_xer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xer_we |=> $stable(xer_rdata));
endmodule

// File: tb/cmp_cr_unit_tb_top.sv
module cmp_cr_unit_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [1:0]  cmp_mode = 0;
  logic [2:0]  cmp_field = 0;
  logic        cmp_we = 0;
  logic [31:0] cr_wdata = 0;
  logic        cr_we = 0;
  logic [31:0] cr_rdata;
  logic [3:0]  fp_flags = 0;
  logic        fp_we = 0;
  logic [31:0] xer_wdata = 0;
  logic        xer_we = 0;
  logic [31:0] xer_rdata;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cmp_cr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .cmp_mode(cmp_mode),
    .cmp_field(cmp_field), .cmp_we(cmp_we), .cr_wdata(cr_wdata), .cr_we(cr_we),
    .cr_rdata(cr_rdata), .fp_flags(fp_flags), .fp_we(fp_we),
    .xer_wdata(xer_wdata), .xer_we(xer_we), .xer_rdata(xer_rdata)
  );

  // {mode, a, b, expected nibble {LT,GT,EQ,SO/UN}}
  localparam int NV = 17;
  localparam logic [69:0] VEC [NV] = '{
    {2'b00, 32'd5,         32'd7,         4'b1000},
    {2'b00, 32'hFFFF_FFFF, 32'd1,         4'b1000},
    {2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 4'b1000},
    {2'b00, 32'd7,         32'd7,         4'b0010},
    {2'b00, 32'd9,         32'd3,         4'b0100},
    {2'b01, 32'hFFFF_FFFF, 32'd1,         4'b0100},
    {2'b01, 32'h8000_0000, 32'h7FFF_FFFF, 4'b0100},
    {2'b01, 32'd3,         32'd3,         4'b0010},
    {2'b01, 32'd0,         32'd1,         4'b1000},
    {2'b10, 32'h3F80_0000, 32'h4000_0000, 4'b1000},
    {2'b10, 32'hBF80_0000, 32'hC000_0000, 4'b0100},
    {2'b10, 32'h0000_0000, 32'h8000_0000, 4'b0010},
    {2'b10, 32'h7FC0_0000, 32'h3F80_0000, 4'b0001},
    {2'b10, 32'h3F80_0000, 32'hFF80_0001, 4'b0001},
    {2'b10, 32'h7F80_0000, 32'h7F7F_FFFF, 4'b0100},
    {2'b10, 32'hFF80_0000, 32'hBF80_0000, 4'b1000},
    {2'b11, 32'h3F80_0000, 32'h3F80_0000, 4'b0010}
  };

  function automatic logic [3:0] nib_of(input logic [31:0] r, input int f);
    return r[31-4*f -: 4];
  endfunction

  function automatic logic [31:0] put_nib(input logic [31:0] r, input int f, input logic [3:0] v);
    logic [31:0] t = r;
    t[31-4*f -: 4] = v;
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_we = 0; cr_we = 0; fp_we = 0; xer_we = 0;
  endtask

  task automatic do_cmp(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b, input int f);
    op_a = a; op_b = b; cmp_mode = m; cmp_field = 3'(f); cmp_we = 1;
  endtask

  initial begin
    logic [31:0] model;
    repeat (3) @(negedge clk);
    check("R1 cr reset", cr_rdata, 32'h0);
    check("R1 xer reset", xer_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);

    model = 0;
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v = VEC[i];
      do_cmp(v[69:68], v[67:36], v[35:4], i % 8);
      tick();
      model = put_nib(model, i % 8, v[3:0]);
      case (v[69:68])
        2'b00:   check("R3/R8 signed", {28'h0, nib_of(cr_rdata, i % 8)}, {28'h0, v[3:0]});
        2'b01:   check("R4/R8 unsigned", {28'h0, nib_of(cr_rdata, i % 8)}, {28'h0, v[3:0]});
        default: check(v[3:0] == 4'b0001 ? "R7 nan" : "R6/R8 float",
                       {28'h0, nib_of(cr_rdata, i % 8)}, {28'h0, v[3:0]});
      endcase
      check("R2 only selected field", cr_rdata, model);
    end

    // R2 layout and isolation from a known pattern
    cr_wdata = 32'h1234_5678; cr_we = 1; tick();
    check("R9 full write", cr_rdata, 32'h1234_5678);
    do_cmp(2'b00, 32'd1, 32'd2, 5); tick();
    check("R2 field 5 placement", cr_rdata, 32'h1234_5878);
    do_cmp(2'b01, 32'd4, 32'd4, 0); tick();
    check("R2 field 0 top nibble", cr_rdata, 32'h2234_5878);

    // R11 exception register masking
    xer_wdata = 32'hFFFF_FFFF; xer_we = 1; tick();
    check("R11 writable bits", xer_rdata, 32'hE000_007F);
    xer_wdata = 32'h1FFF_FF80; xer_we = 1; tick();
    check("R11 reserved ignored", xer_rdata, 32'h0);
    xer_wdata = 32'h8000_0005; xer_we = 1; tick();
    check("R11 so and count", xer_rdata, 32'h8000_0005);

    // R5 summary overflow copied into integer result
    do_cmp(2'b00, 32'd1, 32'd2, 3); tick();
    check("R5 so copy signed", {28'h0, nib_of(cr_rdata, 3)}, 32'h9);
    do_cmp(2'b01, 32'd8, 32'd2, 4); tick();
    check("R5 so copy unsigned", {28'h0, nib_of(cr_rdata, 4)}, 32'h5);
    do_cmp(2'b10, 32'h4000_0000, 32'h3F80_0000, 6); tick();
    check("R6 float ignores so", {28'h0, nib_of(cr_rdata, 6)}, 32'h4);
    // same-cycle clear of SO: compare sees the old value
    do_cmp(2'b00, 32'd3, 32'd3, 7); xer_wdata = 32'h0; xer_we = 1; tick();
    check("R5 old so same cycle", {28'h0, nib_of(cr_rdata, 7)}, 32'h3);
    check("R5 xer updated", xer_rdata, 32'h0);
    do_cmp(2'b00, 32'd3, 32'd3, 7); tick();
    check("R5 so cleared", {28'h0, nib_of(cr_rdata, 7)}, 32'h2);

    // R9 compare wins over full write on its field
    cr_wdata = 32'hFFFF_FFFF; cr_we = 1; do_cmp(2'b00, 32'd0, 32'd9, 2); tick();
    check("R9 compare priority", cr_rdata, 32'hFF8F_FFFF);

    // R10 float status update
    fp_flags = 4'b1010; fp_we = 1; tick();
    check("R10 fp load", cr_rdata, 32'hFA8F_FFFF);
    fp_flags = 4'b0101; fp_we = 1; cr_wdata = 32'h0; cr_we = 1; tick();
    check("R10 fp over full write", cr_rdata, 32'h0500_0000);
    fp_flags = 4'b1111; fp_we = 1; do_cmp(2'b01, 32'd1, 32'd1, 1); tick();
    check("R10 compare over fp", cr_rdata, 32'h0200_0000);

    // R1 asynchronous reset mid-run
    xer_wdata = 32'hE000_0001; xer_we = 1; tick();
    #2 rst_n = 0; #1;
    check("R1 async cr", cr_rdata, 32'h0);
    check("R1 async xer", xer_rdata, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule